// File: doc/BRIEF.md
# Power-Up Strap Capture Controller

This block manages a group of pads that serve two purposes: at power-up each pad is a configuration input whose level is set by an external pull resistor, and afterwards the same pad carries a clock. When the supply-good indication rises, the controller keeps every shared pad driver in high impedance for a fixed number of reference-clock cycles. This gives the pull resistors time to charge the pad and its clock load to a stable level.

At the end of that window the pad levels pass through a two-flop synchronizer and are captured into a bank of configuration bits. In the same step the controller turns on all the pad drivers. The captured bits keep their values for as long as the supply stays good. A fresh sample can only be taken by dropping supply-good and raising it again, which is the only reset the block has. The clock generator reads the captured bits to select its operating mode.

Top module: `strap_sampler`

## Requirements
- R1: While `supplyGood` is low, and without waiting for a clock edge, `padOe` is all zeros, `configValid` is 0 and `strapBits` is all zeros.
- R2: After `supplyGood` rises, `padOe` stays all zeros and `configValid` stays 0 through the first `WINDOW_CYCLES-1` rising clock edges. The design requires `WINDOW_CYCLES` of at least 3 and `CNT_W` wide enough to hold `WINDOW_CYCLES-1`.
- R3: On the `WINDOW_CYCLES`-th rising edge after `supplyGood` rises, bit i of `strapBits` is loaded from `padIn[i]`. A low pad gives 0 and a high pad gives 1.
- R4: Pad levels reach the capture register through a two-flop synchronizer. A pad change made after edge `WINDOW_CYCLES-3` and before edge `WINDOW_CYCLES-2` is captured. A change made after edge `WINDOW_CYCLES-2` is not captured.
- R5: `configValid` and every bit of `padOe` go to 1 together, right after the capture edge. They never turn on before it.
- R6: Once `configValid` is 1, it and `padOe` stay 1 and `strapBits` stays unchanged for as long as `supplyGood` is high, whatever `padIn` does.
- R7: If `supplyGood` drops, including partway through a window, the block returns to the R1 state. The next rise starts a full new window and a fresh capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| supplyGood | input | 1 | Supply-good indication, active high; low acts as the asynchronous power-on reset |
| padIn | input | NUM_PADS | Levels seen at the shared pads |
| padOe | output | NUM_PADS | Output enable for each shared pad driver (1 = drive clock) |
| strapBits | output | NUM_PADS | Captured configuration bits |
| configValid | output | 1 | High once the capture has completed |

## Verification
The bench builds the block with five pads, `WINDOW_CYCLES` = 24 and `CNT_W` = 5. This keeps each window short enough to check the enables after every edge of it, and to run many power cycles. The short window also brings both synchronizer boundary cases within reach at known edges: a change after edge 21, which is captured, and a change after edge 22, which is not. Windows cut short by a supply drop are exercised as well.

// File: rtl/strap_pkg.sv
package strap_pkg;

  // Strobes from the sequencing control to the capture datapath
  typedef struct packed {
    logic capture;  // high during the last window cycle; load on the next edge
    logic drive;    // high once the pads carry clocks
  } strapStrobes_t;

  typedef enum logic [0:0] {
    ST_WINDOW = 1'b0,
    ST_DRIVE  = 1'b1
  } strapState_t;

endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int WINDOW_CYCLES = 28636,
  parameter int CNT_W         = 15
) (
  input  logic          clk,
  input  logic          supplyGood,
  output strapStrobes_t strobes
);

  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(WINDOW_CYCLES - 1);

  strapState_t      state;
  logic [CNT_W-1:0] winCount;
  logic             atLast;

  assign atLast = (winCount == LAST_COUNT);

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) begin
      state    <= ST_WINDOW;
      winCount <= '0;
    end else begin
      case (state)
        ST_WINDOW: begin
          if (atLast) state <= ST_DRIVE;
          else        winCount <= winCount + 1'b1;
        end
        default: state <= ST_DRIVE;
      endcase
    end
  end

  always_comb begin
    strobes.capture = (state == ST_WINDOW) && atLast;
    strobes.drive   = (state == ST_DRIVE);
  end

endmodule

// File: rtl/strap_dp.sv
module strap_dp
  import strap_pkg::*;
#(
  parameter int NUM_PADS = 5
) (
  input  logic                clk,
  input  logic                supplyGood,
  input  logic [NUM_PADS-1:0] padIn,
  input  strapStrobes_t       strobes,
  output logic [NUM_PADS-1:0] strapBits,
  output logic [NUM_PADS-1:0] padOe,
  output logic                configValid
);

  logic [NUM_PADS-1:0] syncFirst;
  logic [NUM_PADS-1:0] syncSecond;
  logic [NUM_PADS-1:0] capturedBits;

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) begin
      syncFirst    <= '0;
      syncSecond   <= '0;
      capturedBits <= '0;
    end else begin
      syncFirst  <= padIn;
      syncSecond <= syncFirst;
      if (strobes.capture) capturedBits <= syncSecond;
    end
  end

  assign strapBits   = capturedBits;
  assign padOe       = {NUM_PADS{strobes.drive}};
  assign configValid = strobes.drive;

endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int NUM_PADS      = 5,
  parameter int WINDOW_CYCLES = 28636,
  parameter int CNT_W         = 15
) (
  input  logic                clk,
  input  logic                supplyGood,
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_PADS-1:0] padOe,
  output logic [NUM_PADS-1:0] strapBits,
  output logic                configValid
);

  strapStrobes_t strobes;

  strap_ctrl #(
    .WINDOW_CYCLES(WINDOW_CYCLES),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .supplyGood(supplyGood),
    .strobes   (strobes)
  );

  strap_dp #(
    .NUM_PADS(NUM_PADS)
  ) u_dp (
    .clk        (clk),
    .supplyGood (supplyGood),
    .padIn      (padIn),
    .strobes    (strobes),
    .strapBits  (strapBits),
    .padOe      (padOe),
    .configValid(configValid)
  );

endmodule

// File: rtl/strap_sampler_chk.sv
module strap_sampler_chk #(
  parameter int NUM_PADS      = 5,
  parameter int WINDOW_CYCLES = 28636
) (
  input logic                clk,
  input logic                supplyGood,
  input logic [NUM_PADS-1:0] padOe,
  input logic [NUM_PADS-1:0] strapBits,
  input logic                configValid
);

  localparam int CW = $clog2(WINDOW_CYCLES + 1) + 1;
  localparam logic [CW-1:0] WIN = CW'(WINDOW_CYCLES);

  // Edges seen since supply-good rose, saturating at the window length
  logic [CW-1:0] edgesSeen;

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood)         edgesSeen <= '0;
    else if (edgesSeen != WIN) edgesSeen <= edgesSeen + 1'b1;
  end

  // R2
  window_quiet_chk: assert property (@(posedge clk) disable iff (!supplyGood)
    (edgesSeen < WIN) |-> (padOe == '0 && !configValid));

  // R5
  drive_on_chk: assert property (@(posedge clk) disable iff (!supplyGood)
    (edgesSeen == WIN) |-> (padOe == '1 && configValid));

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (!supplyGood)
    configValid |=> configValid);

  // R6
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!supplyGood)
    configValid |=> $stable(strapBits));

  // R3
  no_early_bits_chk: assert property (@(posedge clk) disable iff (!supplyGood)
    !configValid |-> (strapBits == '0));

endmodule

bind strap_sampler strap_sampler_chk #(
  .NUM_PADS     (NUM_PADS),
  .WINDOW_CYCLES(WINDOW_CYCLES)
) u_chk (
  .clk        (clk),
  .supplyGood (supplyGood),
  .padOe      (padOe),
  .strapBits  (strapBits),
  .configValid(configValid)
);

// File: tb/test_strap_sampler.sv
module test_strap_sampler;

  localparam int CLK_PERIOD = 10;
  localparam int NP  = 5;
  localparam int WIN = 24;
  localparam int CW  = 5;

  logic          clk = 1'b0;
  logic          supplyGood = 1'b0;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOe;
  logic [NP-1:0] strapBits;
  logic          configValid;

  int vectors = 0;
  int miscompares = 0;

  strap_sampler #(
    .NUM_PADS(NP), .WINDOW_CYCLES(WIN), .CNT_W(CW)
  ) i_strap_sampler (
    .clk(clk), .supplyGood(supplyGood), .padIn(padIn),
    .padOe(padOe), .strapBits(strapBits), .configValid(configValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkOff(input string req);
    checkVal(req, "padOe", 32'(padOe), 32'(0));
    checkVal(req, "configValid", 32'(configValid), 32'(0));
    checkVal(req, "strapBits", 32'(strapBits), 32'(0));
  endtask

  // Raise supply with pads at 'early'; after edge changeAt (0 = never) set 'late'.
  task automatic runWindow(input logic [NP-1:0] early, input int changeAt,
                           input logic [NP-1:0] late, input logic [NP-1:0] expBits,
                           input string req);
    padIn = early;
    @(negedge clk);
    supplyGood = 1'b1;
    for (int k = 1; k < WIN; k++) begin
      @(negedge clk);
      checkVal("R2", "padOe in window", 32'(padOe), 32'(0));
      checkVal("R2", "configValid in window", 32'(configValid), 32'(0));
      if (k == changeAt) padIn = late;
    end
    @(negedge clk);
    checkVal("R5", "padOe after capture", 32'(padOe), 32'({NP{1'b1}}));
    checkVal("R5", "configValid after capture", 32'(configValid), 32'(1));
    checkVal(req, "strapBits", 32'(strapBits), 32'(expBits));
  endtask

  task automatic powerDown();
    @(negedge clk);
    supplyGood = 1'b0;
    #1;
    checkOff("R1");
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    checkOff("R1");
  endtask

  task automatic testBasicCapture();
    runWindow(5'b10110, 0, '0, 5'b10110, "R3");
    powerDown();
    runWindow(5'b01001, 0, '0, 5'b01001, "R3");
    powerDown();
    runWindow(5'b00000, 0, '0, 5'b00000, "R3");
    powerDown();
    runWindow(5'b11111, 0, '0, 5'b11111, "R3");
    powerDown();
  endtask

  task automatic testIgnoreAfter();
    runWindow(5'b11010, 0, '0, 5'b11010, "R3");
    for (int i = 0; i < 8; i++) begin
      padIn = ~padIn ^ NP'(i);
      @(negedge clk);
      checkVal("R6", "strapBits held", 32'(strapBits), 32'(5'b11010));
      checkVal("R6", "padOe held", 32'(padOe), 32'({NP{1'b1}}));
      checkVal("R6", "configValid held", 32'(configValid), 32'(1));
    end
    powerDown();
  endtask

  task automatic testSyncBoundary();
    // change after edge WIN-2 misses the capture
    runWindow(5'b00111, WIN-2, 5'b11000, 5'b00111, "R4");
    powerDown();
    // change after edge WIN-3 reaches the capture
    runWindow(5'b00111, WIN-3, 5'b11000, 5'b11000, "R4");
    powerDown();
  endtask

  task automatic testAbortedWindow();
    padIn = 5'b10101;
    @(negedge clk);
    supplyGood = 1'b1;
    repeat (10) @(negedge clk);
    checkVal("R7", "padOe mid window", 32'(padOe), 32'(0));
    supplyGood = 1'b0;
    #1;
    checkOff("R7");
    repeat (2) @(negedge clk);
    runWindow(5'b01110, 0, '0, 5'b01110, "R7");
    powerDown();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    testReset();
    testBasicCapture();
    testIgnoreAfter();
    testSyncBoundary();
    testAbortedWindow();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule